// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps time of day and calendar date as a chain of packed BCD counters: seconds, minutes, 24-hour hours, weekday, day of month, month and a two-digit year. A one-cycle `tick` pulse, produced elsewhere once per second, advances the chain by one second. Each carry moves into the next field up. The day-of-month limit follows the current month and year, so months of 28, 29, 30 and 31 days end correctly without help from outside.

A host sets the time by presenting every field on the `set_*` inputs and pulsing `load`. All fields are written in the same cycle. Every field is always visible in parallel on the outputs, so a register window can read them directly. Each field is eight bits: the upper nibble holds the tens digit and the lower nibble holds the units digit.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs read 00:00:00, weekday 01, day 01, month 01 and year 00.
- R2: Seconds count 00 to 59 in BCD. A tick at 59 gives 00 and advances minutes by one. A tick below 59 leaves minutes unchanged.
- R3: Minutes count 00 to 59 in BCD. They wrap to 00 and carry into hours.
- R4: Hours count 00 to 23 in BCD. They wrap to 00 and carry into the day of month.
- R5: The day of month counts from 01. Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. Rolling past the last day gives 01 and advances the month.
- R6: February (month 02) ends after day 29 when the year is a multiple of four. Year 00 counts as a leap year. In every other year February ends after day 28.
- R7: Month 12 rolls to 01 and advances the year. Year 99 advances to 00.
- R8: The weekday counts 01 to 07. It advances each time the day of month advances, and 07 is followed by 01.
- R9: Fields change only in the clock edge that samples a tick or a load. The new value appears on the outputs one cycle after that edge. With neither input high, every output holds.
- R10: A load writes every field from the `set_*` inputs at one edge. A tick in the same cycle as a load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| load | input | 1 | Write all fields from the set inputs |
| set_secs | input | 8 | BCD seconds to load |
| set_mins | input | 8 | BCD minutes to load |
| set_hours | input | 8 | BCD hours to load |
| set_wday | input | 8 | BCD weekday to load (01-07) |
| set_mday | input | 8 | BCD day of month to load |
| set_mon | input | 8 | BCD month to load |
| set_yr | input | 8 | BCD year to load |
| secs | output | 8 | BCD seconds |
| mins | output | 8 | BCD minutes |
| hours | output | 8 | BCD hours |
| wday | output | 8 | BCD weekday |
| mday | output | 8 | BCD day of month |
| mon | output | 8 | BCD month |
| yr | output | 8 | BCD year |

## Verification
Two things can happen in the same edge: a host load and a one-second tick. Also, a single tick can ripple a carry through every field at once. The bench holds `tick` high during a load and expects the loaded values to stay unchanged. Separately, it loads 23:59:59 on the last day of every month in every year 00 to 99, and on the day before that last day. It then sends one tick and compares all seven fields with a model computed in integer arithmetic. Two long free runs across a February boundary, in a leap year and in a common year, compare the chain against that model on every tick.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;
   localparam int FIELD_W = 8;
   localparam int NIB_W   = FIELD_W / 2;

   typedef logic [FIELD_W-1:0] bcd_t;

   localparam bcd_t BCD_SEC_MAX  = 8'h59;
   localparam bcd_t BCD_HOUR_MAX = 8'h23;
   localparam bcd_t BCD_MON_MAX  = 8'h12;
   localparam bcd_t BCD_YR_MAX   = 8'h99;
   localparam bcd_t BCD_ZERO     = 8'h00;
   localparam bcd_t BCD_ONE      = 8'h01;

   // increment a two-digit packed BCD value by one (no wrap handling beyond 99)
   function automatic bcd_t bcd_next(input bcd_t v);
      logic [NIB_W-1:0] tens;
      logic [NIB_W-1:0] units;
      tens  = v[FIELD_W-1:NIB_W];
      units = v[NIB_W-1:0];
      if (units >= 4'd9) begin
         units = '0;
         tens  = tens + 4'd1;
      end else begin
         units = units + 4'd1;
      end
      return {tens, units};
   endfunction

   // binary 0..99 to packed BCD, for elaboration-time constants
   function automatic bcd_t to_bcd(input int n);
      return bcd_t'(((n / 10) << NIB_W) | (n % 10));
   endfunction
endpackage

// File: rtl/bcdcal_field.sv
module bcdcal_field
   import bcdcal_pkg::*;
#(
   parameter bcd_t RST_VAL = 8'h00
)(
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic load,
   input  bcd_t load_val,
   input  bcd_t lo,
   input  bcd_t hi,
   output bcd_t value,
   output logic carry
);
   logic at_top;
   assign at_top = (value == hi);
   assign carry  = inc && !load && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= RST_VAL;
      else if (load)
         value <= load_val;
      else if (inc)
         value <= at_top ? lo : bcd_next(value);
   end
endmodule

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len
   import bcdcal_pkg::*;
#(
   parameter bit LEAP_RULE = 1'b1
)(
   input  bcd_t mon,
   input  bcd_t yr,
   output bcd_t last_day
);
   logic leap;

   generate
      if (LEAP_RULE) begin : g_leap
         logic [NIB_W-1:0] tens;
         logic [NIB_W-1:0] units;
         assign tens  = yr[FIELD_W-1:NIB_W];
         assign units = yr[NIB_W-1:0];
         // multiple of four in decimal, judged on the two BCD digits
         assign leap = tens[0] ? ((units == 4'd2) || (units == 4'd6))
                               : ((units == 4'd0) || (units == 4'd4) || (units == 4'd8));
      end else begin : g_noleap
         logic unused_yr;
         assign unused_yr = ^yr;
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mon)
         8'h02:                      last_day = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import bcdcal_pkg::*;
#(
   parameter bit LEAP_RULE = 1'b1,
   parameter int WDAY_LAST = 7
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  logic [7:0] set_secs,
   input  logic [7:0] set_mins,
   input  logic [7:0] set_hours,
   input  logic [7:0] set_wday,
   input  logic [7:0] set_mday,
   input  logic [7:0] set_mon,
   input  logic [7:0] set_yr,
   output logic [7:0] secs,
   output logic [7:0] mins,
   output logic [7:0] hours,
   output logic [7:0] wday,
   output logic [7:0] mday,
   output logic [7:0] mon,
   output logic [7:0] yr
);
   localparam bcd_t WDAY_MAX = to_bcd(WDAY_LAST);

   generate
      if (WDAY_LAST < 2 || WDAY_LAST > 9) begin : g_bad_wday
         $error("WDAY_LAST must lie in 2..9");
      end
      if (FIELD_W != 8) begin : g_bad_width
         $error("fields must be two BCD digits");
      end
   endgenerate

   logic c_sec, c_min, c_hour, c_mday, c_mon;
   logic c_wday_unused, c_yr_unused;
   bcd_t mday_last;
   logic step;

   assign step = tick && !load;

   bcdcal_month_len #(.LEAP_RULE(LEAP_RULE)) u_len (
      .mon(mon), .yr(yr), .last_day(mday_last)
   );

   bcdcal_field #(.RST_VAL(BCD_ZERO)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(step), .load(load), .load_val(set_secs),
      .lo(BCD_ZERO), .hi(BCD_SEC_MAX), .value(secs), .carry(c_sec));

   bcdcal_field #(.RST_VAL(BCD_ZERO)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .load(load), .load_val(set_mins),
      .lo(BCD_ZERO), .hi(BCD_SEC_MAX), .value(mins), .carry(c_min));

   bcdcal_field #(.RST_VAL(BCD_ZERO)) u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .load(load), .load_val(set_hours),
      .lo(BCD_ZERO), .hi(BCD_HOUR_MAX), .value(hours), .carry(c_hour));

   bcdcal_field #(.RST_VAL(BCD_ONE)) u_wday (
      .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(load), .load_val(set_wday),
      .lo(BCD_ONE), .hi(WDAY_MAX), .value(wday), .carry(c_wday_unused));

   bcdcal_field #(.RST_VAL(BCD_ONE)) u_mday (
      .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(load), .load_val(set_mday),
      .lo(BCD_ONE), .hi(mday_last), .value(mday), .carry(c_mday));

   bcdcal_field #(.RST_VAL(BCD_ONE)) u_mon (
      .clk(clk), .rst_n(rst_n), .inc(c_mday), .load(load), .load_val(set_mon),
      .lo(BCD_ONE), .hi(BCD_MON_MAX), .value(mon), .carry(c_mon));

   bcdcal_field #(.RST_VAL(BCD_ZERO)) u_yr (
      .clk(clk), .rst_n(rst_n), .inc(c_mon), .load(load), .load_val(set_yr),
      .lo(BCD_ZERO), .hi(BCD_YR_MAX), .value(yr), .carry(c_yr_unused));

   logic unused_carries;
   assign unused_carries = c_wday_unused ^ c_yr_unused;
endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       load,
   input logic [7:0] set_secs,
   input logic [7:0] set_mins,
   input logic [7:0] set_hours,
   input logic [7:0] set_wday,
   input logic [7:0] set_mday,
   input logic [7:0] set_mon,
   input logic [7:0] set_yr,
   input logic [7:0] secs,
   input logic [7:0] mins,
   input logic [7:0] hours,
   input logic [7:0] wday,
   input logic [7:0] mday,
   input logic [7:0] mon,
   input logic [7:0] yr
);
   logic adv, day_end;
   assign adv     = tick && !load;
   assign day_end = adv && secs == 8'h59 && mins == 8'h59 && hours == 8'h23;

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      adv && secs == 8'h59 |=> secs == 8'h00);                                  // R2
   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      adv && secs != 8'h59 |=> $stable(mins));                                  // R2
   AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      adv && secs == 8'h59 && mins == 8'h59 |=> mins == 8'h00);                 // R3
   AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      day_end |=> hours == 8'h00);                                              // R4
   AST_APR_END: assert property (@(posedge clk) disable iff (!rst_n)
      day_end && mon == 8'h04 && mday == 8'h30 |=> mday == 8'h01 && mon == 8'h05); // R5
   AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
      day_end && mon == 8'h02 && mday == 8'h28 && yr == 8'h00 |=> mday == 8'h29);  // R6
   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      day_end && mon == 8'h12 && mday == 8'h31 && yr == 8'h99
      |=> yr == 8'h00 && mon == 8'h01);                                         // R7
   AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      day_end && wday == 8'h07 |=> wday == 8'h01);                              // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !load |=> $stable(secs) && $stable(mins) && $stable(hours)
                      && $stable(wday) && $stable(mday) && $stable(mon) && $stable(yr)); // R9
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> secs == $past(set_secs) && mins == $past(set_mins)
            && hours == $past(set_hours) && wday == $past(set_wday)
            && mday == $past(set_mday) && mon == $past(set_mon)
            && yr == $past(set_yr));                                            // R10
endmodule

bind bcd_calendar_clock bcdcal_checker u_chk (.*);

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic load = 1'b0;
   logic [7:0] set_secs = '0, set_mins = '0, set_hours = '0, set_wday = '0;
   logic [7:0] set_mday = '0, set_mon = '0, set_yr = '0;
   logic [7:0] secs, mins, hours, wday, mday, mon, yr;

   int total = 0;
   int bad = 0;
   int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;

   always #5 clk = ~clk;

   bcd_calendar_clock u0 (.*);

   function automatic logic [7:0] bcd(input int n);
      return 8'(((n / 10) << 4) | (n % 10));
   endfunction

   function automatic int mlen(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_mi++;
         if (m_mi == 60) begin
            m_mi = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0;
               m_w = (m_w == 7) ? 1 : m_w + 1;
               if (m_d == mlen(m_mo, m_y)) begin
                  m_d = 1;
                  if (m_mo == 12) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                  else m_mo++;
               end else m_d++;
            end
         end
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (model %0d-%0d-%0d %0d:%0d:%0d w%0d)",
                  req, act, exp, m_y, m_mo, m_d, m_h, m_mi, m_s, m_w);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, secs,  bcd(m_s));
      chk(req, mins,  bcd(m_mi));
      chk(req, hours, bcd(m_h));
      chk(req, wday,  bcd(m_w));
      chk(req, mday,  bcd(m_d));
      chk(req, mon,   bcd(m_mo));
      chk(req, yr,    bcd(m_y));
   endtask

   // drive a load at a falling edge; it takes effect at the next rising edge
   task automatic do_load(input int y, input int mo, input int d, input int h,
                          input int mi, input int s, input int w, input logic with_tick);
      @(negedge clk);
      load = 1'b1; tick = with_tick;
      set_yr = bcd(y); set_mon = bcd(mo); set_mday = bcd(d);
      set_hours = bcd(h); set_mins = bcd(mi); set_secs = bcd(s); set_wday = bcd(w);
      m_y = y; m_mo = mo; m_d = d; m_h = h; m_mi = mi; m_s = s; m_w = w;
      @(negedge clk);
      load = 1'b0; tick = 1'b0;
   endtask

   task automatic one_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      model_step();
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 0;
      repeat (3) @(negedge clk);
      chk_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after release");

      // R9: idle cycles hold every field
      do_load(45, 7, 14, 10, 20, 30, 3, 1'b0);
      chk_all("R10 load");
      repeat (4) @(negedge clk);
      chk_all("R9 idle hold");
      one_tick();
      chk_all("R9 single tick");
      repeat (3) @(negedge clk);
      chk_all("R9 hold after tick");

      // R10: load and tick together, tick dropped
      do_load(12, 3, 9, 8, 7, 59, 5, 1'b1);
      chk_all("R10 load beats tick");

      // R8: weekday wrap at day end
      do_load(50, 5, 10, 23, 59, 59, 7, 1'b0);
      one_tick();
      chk_all("R8 weekday wrap");

      // R5 R6 R7: every month of every year, last day and day before
      for (int y = 0; y < 100; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            do_load(y, mo, mlen(mo, y), 23, 59, 59, (mo % 7) + 1, 1'b0);
            one_tick();
            chk_all((mo == 2) ? "R6 feb end" : (mo == 12) ? "R7 year end" : "R5 month end");
            do_load(y, mo, mlen(mo, y) - 1, 23, 59, 59, 2, 1'b0);
            one_tick();
            chk_all((mo == 2) ? "R6 feb last-1" : "R5 month last-1");
         end
      end

      // R2 R3 R4: free runs through a February end, leap and common
      do_load(24, 2, 28, 23, 0, 0, 4, 1'b0);
      for (int i = 0; i < 3700; i++) begin
         one_tick();
         chk_all("R2 R3 R4 run leap");
      end
      do_load(23, 2, 28, 23, 0, 0, 6, 1'b0);
      for (int i = 0; i < 3700; i++) begin
         one_tick();
         chk_all("R2 R3 R4 run common");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule